// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a processor reach a bank of registers that lives in a slow, always-on domain. It does not map that bank into the processor's address space. Software instead sees a window of four 32-bit registers. It loads a mode word, a far-side address and, for a write, a data word. It then sets a start bit and busy-waits on the control register until it reads zero. While it is busy, the bridge runs exactly one request/acknowledge exchange on its far-side register port. For a read, it keeps the returned word in the data register.

The far-side request is held until the far side acknowledges. The address, the data and the mode fields are driven straight from the window registers. These registers are frozen for the whole transaction, so the far side sees a stable request. Software writes that arrive during a transaction cannot corrupt it, and a second start request made during a transaction is dropped.

Top module: `ibr_bridge`

## Requirements
- R1: The word offset on `cpu_addr` (byte address bits 3:2) selects the register: 0 control, 1 mode, 2 far address, 3 data. The address and data registers read back the full written word. The mode register keeps only bits 7:0 and reads zero above them.
- R2: When idle, a CPU write to the control register with bit 0 set raises `far_req` on the next clock cycle.
- R3: The control register reads 1 from the cycle after the start write until the cycle after the acknowledge. It reads 0 after that. With an acknowledge given L cycles after the request is first seen, busy lasts exactly L+2 cycles.
- R4: Mode bit 0 clear (for example 0x00) makes a read: `far_we` is low, and the value on `far_rdata` in the acknowledge cycle is captured into the data register.
- R5: Mode 0xF1 makes a full-word write: `far_we` is high and `far_be` is 4'hF (mode bits 7:4). `far_addr` and `far_wdata` equal the address and data registers, and the data register keeps its value afterwards.
- R6: `far_req` stays high until `far_ack` is seen and drops in the cycle after it. Each start produces exactly one far-side transaction.
- R7: A start request made while a transaction is in progress is ignored and produces no extra far-side transaction.
- R8: Writes to the mode, address and data registers while busy are ignored. Afterwards, all three still read the values that were used by the transaction.
- R9: Reset clears all four registers and deasserts `far_req`.
- R10: A control write with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 2 | Register word offset (byte address bits 3:2) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Register read data, combinational from `cpu_addr` |
| far_req | output | 1 | Far-side transaction request |
| far_we | output | 1 | Far-side write (1) or read (0) |
| far_be | output | 4 | Far-side byte enables |
| far_addr | output | 32 | Far-side register address |
| far_wdata | output | 32 | Far-side write data |
| far_ack | input | 1 | Far-side acknowledge |
| far_rdata | input | 32 | Far-side read data, valid with `far_ack` |

## Verification
The main function is tested with three kinds of transaction:
- A full-word write checks the control bits driven to the far side and the data register's persistence.
- A read checks the capture path separately from the write path.
- A write disturbed by extra start and register writes while busy shows whether the in-flight transaction is protected.

Each transaction is run at acknowledge latencies of 0, 3 and 6 cycles. Counting the busy reads at each latency shows whether busy clears exactly one cycle after the acknowledge or is off by one. A scoreboard of expected far-side transactions catches any missing, duplicate or altered request.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    localparam int NUM_REGS    = 4;
    localparam int REG_IDX_W   = $clog2(NUM_REGS);
    localparam logic [REG_IDX_W-1:0] IDX_CTRL = 2'd0;
    localparam logic [REG_IDX_W-1:0] IDX_MODE = 2'd1;
    localparam logic [REG_IDX_W-1:0] IDX_ADDR = 2'd2;
    localparam logic [REG_IDX_W-1:0] IDX_DATA = 2'd3;
    // mode word layout: bit 0 write flag, enables from MODE_BE_LO upward
    localparam int MODE_WR_BIT = 0;
    localparam int MODE_BE_LO  = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ibr_pkg::*;
(
    input  logic                 sel_i,
    input  logic                 we_i,
    input  logic [REG_IDX_W-1:0] idx_i,
    output logic [NUM_REGS-1:0]  wr_strb_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_strb
        assign wr_strb_o[i] = sel_i && we_i && (idx_i == REG_IDX_W'(i));
    end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic wr_flag_i,
    input  logic far_ack_i,
    output logic busy_o,
    output logic far_req_o,
    output logic capture_o
);
    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_IDLE: if (start_i)   seq_d.state = SEQ_REQ;
            SEQ_REQ:  if (far_ack_i) seq_d.state = SEQ_DONE;
            SEQ_DONE:                seq_d.state = SEQ_IDLE;
            default:                 seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{state: SEQ_IDLE};
        else        seq_q <= seq_d;
    end

    assign busy_o    = (seq_q.state != SEQ_IDLE);
    assign far_req_o = (seq_q.state == SEQ_REQ);
    assign capture_o = far_req_o && far_ack_i && !wr_flag_i;

    // R2: an accepted start raises the request next cycle
    assert_start_raises_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> far_req_o);
    // R6: request held until acknowledge
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        far_req_o && !far_ack_i |=> far_req_o);
    // R6: request dropped after acknowledge
    assert_req_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        far_req_o && far_ack_i |=> !far_req_o);
    // R3: busy lasts exactly one cycle past the acknowledge
    assert_busy_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        far_req_o && far_ack_i |=> busy_o);
    assert_busy_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        far_req_o && far_ack_i |-> ##2 !busy_o);
    // R9: no request while idle
    assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !far_req_o);
endmodule

// File: rtl/ibr_regs.sv
module ibr_regs
    import ibr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              wr_mode_i,
    input  logic              wr_addr_i,
    input  logic              wr_data_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] far_rdata_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (!busy_i) begin
            if (wr_mode_i) regs_d.mode = wdata_i[MODE_W-1:0];
            if (wr_addr_i) regs_d.addr = wdata_i;
            if (wr_data_i) regs_d.data = wdata_i;
        end
        if (capture_i) regs_d.data = far_rdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mode_o = regs_q.mode;
    assign addr_o = regs_q.addr;
    assign data_o = regs_q.data;

    // R8: window fields frozen during a transaction
    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(regs_q.addr));
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(regs_q.mode));
    // R4: read data captured in the acknowledge cycle
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (regs_q.data == $past(far_rdata_i)));
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_sel,
    input  logic                    cpu_we,
    input  logic [REG_IDX_W+1:2]    cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    far_req,
    output logic                    far_we,
    output logic [DATA_W/8-1:0]     far_be,
    output logic [DATA_W-1:0]       far_addr,
    output logic [DATA_W-1:0]       far_wdata,
    input  logic                    far_ack,
    input  logic [DATA_W-1:0]       far_rdata
);
    localparam int BE_W   = DATA_W / 8;
    localparam int MODE_W = MODE_BE_LO + BE_W;

    logic [NUM_REGS-1:0] wr_strb;
    logic                busy, capture, start;
    logic [MODE_W-1:0]   mode;
    logic [DATA_W-1:0]   addr_r, data_r;

    ibr_decode u_decode (
        .sel_i     (cpu_sel),
        .we_i      (cpu_we),
        .idx_i     (cpu_addr),
        .wr_strb_o (wr_strb)
    );

    assign start = wr_strb[IDX_CTRL] && cpu_wdata[0];

    ibr_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .wr_flag_i (mode[MODE_WR_BIT]),
        .far_ack_i (far_ack),
        .busy_o    (busy),
        .far_req_o (far_req),
        .capture_o (capture)
    );

    ibr_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy),
        .wr_mode_i   (wr_strb[IDX_MODE]),
        .wr_addr_i   (wr_strb[IDX_ADDR]),
        .wr_data_i   (wr_strb[IDX_DATA]),
        .wdata_i     (cpu_wdata),
        .capture_i   (capture),
        .far_rdata_i (far_rdata),
        .mode_o      (mode),
        .addr_o      (addr_r),
        .data_o      (data_r)
    );

    assign far_we    = mode[MODE_WR_BIT];
    assign far_be    = mode[MODE_W-1:MODE_BE_LO];
    assign far_addr  = addr_r;
    assign far_wdata = data_r;

    always_comb begin
        unique case (cpu_addr)
            IDX_CTRL: cpu_rdata = {{(DATA_W-1){1'b0}}, busy};
            IDX_MODE: cpu_rdata = {{(DATA_W-MODE_W){1'b0}}, mode};
            IDX_ADDR: cpu_rdata = addr_r;
            default:  cpu_rdata = data_r;
        endcase
    end
endmodule

// File: tb/ibr_bridge_tb.sv
module ibr_bridge_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [3:2]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        far_req, far_we;
    logic [3:0]  far_be;
    logic [31:0] far_addr, far_wdata;
    logic        far_ack = 1'b0;
    logic [31:0] far_rdata = '0;

    int n_checks = 0, n_fail = 0, n_txn = 0, ack_lat = 0;

    typedef struct { bit we; bit [3:0] be; bit [31:0] addr; bit [31:0] wdata; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ibr_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .far_req(far_req), .far_we(far_we), .far_be(far_be),
        .far_addr(far_addr), .far_wdata(far_wdata),
        .far_ack(far_ack), .far_rdata(far_rdata)
    );

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic cpu_write(input logic [3:0] ofs, input logic [31:0] v);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = ofs[3:2]; cpu_wdata = v;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [3:0] ofs, output logic [31:0] v);
        cpu_addr = ofs[3:2];
        #1 v = cpu_rdata;
    endtask

    // counts busy reads, one per cycle, starting at the current negedge
    task automatic poll_idle(output int cycles);
        logic [31:0] v;
        cycles = 0;
        for (int i = 0; i < 1000; i++) begin
            cpu_read(4'h0, v);
            if (v == 0) break;
            cycles++;
            @(negedge clk);
        end
    endtask

    // far-side model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (far_req && !far_ack) begin
                for (int i = 0; i < ack_lat; i++) begin
                    @(negedge clk);
                    check("R6 req held", {31'b0, far_req}, 32'd1);
                end
                if (exp_q.size() == 0) begin
                    check("R7 unexpected transaction", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R4/R5 far_we", {31'b0, far_we}, {31'b0, e.we});
                    check("R5 far_be", {28'b0, far_be}, {28'b0, e.be});
                    check("R5 far_addr", far_addr, e.addr);
                    if (e.we) check("R5 far_wdata", far_wdata, e.wdata);
                end
                far_rdata = model_rd(far_addr);
                far_ack = 1'b1;
                n_txn++;
                @(negedge clk);
                check("R6 req dropped", {31'b0, far_req}, 32'd0);
                far_ack = 1'b0;
                far_rdata = '0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        report();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cyc, base;
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        for (int r = 0; r < 4; r++) begin
            cpu_read(4'(r*4), v);
            check("R9 reset reg", v, 32'h0);
        end
        check("R9 req low", {31'b0, far_req}, 32'd0);

        // R1 register window
        cpu_write(4'h8, 32'h1234_5678);
        cpu_write(4'hC, 32'hDEAD_BEEF);
        cpu_write(4'h4, 32'h0000_01F1);
        cpu_read(4'h8, v); check("R1 addr readback", v, 32'h1234_5678);
        cpu_read(4'hC, v); check("R1 data readback", v, 32'hDEAD_BEEF);
        cpu_read(4'h4, v); check("R1 mode readback", v, 32'h0000_00F1);

        // R10 control write without bit 0
        cpu_write(4'h0, 32'h0000_0002);
        check("R10 no req", {31'b0, far_req}, 32'd0);
        cpu_read(4'h0, v); check("R10 ctrl idle", v, 32'h0);

        // R5 full-word write, latency 3
        ack_lat = 3; base = n_txn;
        e = '{we: 1'b1, be: 4'hF, addr: 32'h1234_5678, wdata: 32'hDEAD_BEEF};
        exp_q.push_back(e);
        cpu_write(4'h0, 32'h1);
        check("R2 req raised", {31'b0, far_req}, 32'd1);
        poll_idle(cyc);
        check("R3 busy cycles lat3", cyc, 32'd5);
        check("R6 one txn", n_txn - base, 32'd1);
        cpu_read(4'hC, v); check("R5 data kept", v, 32'hDEAD_BEEF);

        // R4 read, latency 0
        ack_lat = 0; base = n_txn;
        cpu_write(4'h4, 32'h0);
        cpu_write(4'h8, 32'h0000_ABCD);
        e = '{we: 1'b0, be: 4'h0, addr: 32'h0000_ABCD, wdata: 32'h0};
        exp_q.push_back(e);
        cpu_write(4'h0, 32'h1);
        poll_idle(cyc);
        check("R3 busy cycles lat0", cyc, 32'd2);
        cpu_read(4'hC, v); check("R4 captured read", v, model_rd(32'h0000_ABCD));

        // R7 / R8 disturbance during a write, latency 6
        ack_lat = 6; base = n_txn;
        cpu_write(4'h4, 32'hF1);
        cpu_write(4'h8, 32'h0000_0C0C);
        cpu_write(4'hC, 32'h5555_AAAA);
        e = '{we: 1'b1, be: 4'hF, addr: 32'h0000_0C0C, wdata: 32'h5555_AAAA};
        exp_q.push_back(e);
        cpu_write(4'h0, 32'h1);
        cpu_write(4'h0, 32'h1);
        cpu_write(4'h8, 32'h0000_0999);
        cpu_write(4'hC, 32'h0000_0111);
        cpu_write(4'h4, 32'h0);
        poll_idle(cyc);
        repeat (10) @(negedge clk);
        check("R7 single txn", n_txn - base, 32'd1);
        check("R7 queue drained", exp_q.size(), 32'd0);
        cpu_read(4'h8, v); check("R8 addr kept", v, 32'h0000_0C0C);
        cpu_read(4'hC, v); check("R8 data kept", v, 32'h5555_AAAA);
        cpu_read(4'h4, v); check("R8 mode kept", v, 32'h0000_00F1);

        // R9 reset from a dirty state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 4; r++) begin
            cpu_read(4'(r*4), v);
            check("R9 reset clears", v, 32'h0);
        end

        report();
        $finish;
    end
endmodule